// File: doc/BRIEF.md
# Receive-Enable Calibration Sequencer

This block trains the receive-enable delay of one memory channel. The channel has four byte-lane groups, and each group listens to two data-strobe lanes. For each group in turn, the sequencer adjusts a delay made of four fields: coarse (whole clocks), phase (half clocks), tap and fine. After every adjustment it reads the strobe level through a probe handshake. Each decision rests on two probe results, one per lane of the group. The search runs in this order: find the strobe low, locate the first rising edge, back off over the preamble, then locate the edge again. The result is then pulled back by half a clock.

When all four groups are done, the smallest coarse value becomes a coarse setting shared by the whole channel. Each group keeps its own surplus as a two-bit preamble offset. One card type wires its strobes differently. For that type the sequencer probes a single lane per group, twice per decision, and adds one tap to every result. If any step would push the coarse value outside 0..15, the run stops and an error is flagged.

Top module: `rxen_calib`

## Requirements
- R1: After reset `done`, `error` and `probeReq` are low and `grpTiming` and `chanWord` are zero. A `start` pulse from idle, done or error sets every group to coarse = `initCoarse` with tap, fine, phase and preamble zero, and clears `done` and `error`.
- R2: `probeReq` stays high with a stable `probeLane` until `probeAck`. `probeLevel` is taken in the `probeAck` cycle. Every search decision uses exactly two probes.
- R3: In normal mode, group g probes lanes 2g and 2g+1. When `altCard` is high at start, groups 0,1,2,3 probe lanes 0,3,6,5, and both probes of a decision use the same lane.
- R4: Each group runs this search. (a) Step forward a quarter clock while either lane is high. (b) Edge search: add 2 taps, step forward a quarter clock while both lanes are low, step back one quarter, then add one fine unit while the two lanes are not both high. (c) Step forward one quarter. (d) Step back one whole clock while either lane is high. (e) Run the edge search again. (f) Step back half a clock.
- R5: `rateSel`=0 gives 12 taps per half clock and 1 fine unit per tap. `rateSel`=1 gives 9 taps and 8 fine units per tap. A quarter step is tapBound/2 taps plus, when tapBound is odd, fineBound/2 fine units. Fine wraps into tap, tap wraps into phase by 2, and phase wraps at 4 into coarse. Phase is always 0 or 2.
- R6: A group's delay fields change only between probes and never while `probeReq` is high, so each probe sees the last applied step.
- R7: In the alternate mode, each group gets one extra tap after the half-clock step back, and any carry from it is normalized.
- R8: At the end, the shared coarse equals the minimum coarse over the groups. Each group's preamble field is the low two bits of its own coarse minus that minimum.
- R9: Group g's timing word is `grpTiming[32g+31:32g]`: tap in bits 31:28, fine in 26:24, phase in 23:22, preamble in 21:20, other bits zero. `chanWord` holds the coarse value in bits 10:7, other bits zero. During the search it shows the active group's coarse.
- R10: If a step would make coarse negative or above 15, the step is not applied, `error` goes high and stays high with no further probes until the next `start`, and `done` stays low.
- R11: `done` goes high two cycles after the last step of group 3 and stays high, with the outputs frozen, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin calibration (one-cycle pulse) |
| rateSel | input | 1 | Delay-line resolution select, sampled at start |
| altCard | input | 1 | Alternate lane map and extra tap, sampled at start |
| initCoarse | input | 4 | Starting coarse delay for all groups |
| probeReq | output | 1 | Strobe sample request |
| probeLane | output | 3 | Lane to sample |
| probeAck | input | 1 | Sample response valid |
| probeLevel | input | 1 | Sampled strobe level |
| grpTiming | output | 128 | Four packed per-group timing words |
| chanWord | output | 32 | Channel word carrying the coarse value |
| done | output | 1 | Calibration finished, results valid |
| error | output | 1 | Coarse under- or overflow, run aborted |

## Verification
The bench answers probes at the falling edge and computes each level from the delay fields the block shows on its ports. A step applied at one rising edge is therefore visible at the following falling edge, before the next probe is answered. The final timing words are compared with a reference search computed in the bench over a single linear fine-unit position. They are sampled at the first falling edge where `done` is high, which comes two cycles after the last step. The reload after `start` is checked at the first falling edge after the start edge. The error path is checked at the falling edge where `error` first shows, then again some cycles later to confirm that the state is held.

// File: rtl/rxen_calib_pkg.sv
package rxen_calib_pkg;
  localparam int NUM_GROUPS = 4;
  localparam int GRP_W = $clog2(NUM_GROUPS);
  localparam int LANE_W = 3;
  localparam int COARSE_W = 4;
  localparam int TAP_W = 4;
  localparam int FINE_W = 3;
  localparam int PHASE_W = 2;
  localparam int PRE_W = 2;
  localparam int WORD_W = 32;
  localparam int TAP_LSB = 28;
  localparam int FINE_LSB = 24;
  localparam int PHASE_LSB = 22;
  localparam int PRE_LSB = 20;
  localparam int CH_COARSE_LSB = 7;
  localparam int PHASE_BOUND = 4;
  localparam int PHASE_STEP = 2;
  localparam int MAX_COARSE = (1 << COARSE_W) - 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_TAP2, OP_TAP1, OP_QTR_FWD, OP_QTR_BACK,
    OP_FINE, OP_FULL_BACK, OP_HALF_BACK
  } stepOp_t;

  typedef struct packed {
    logic             loadInit;
    logic             stepEn;
    stepOp_t          stepOp;
    logic [GRP_W-1:0] grpSel;
    logic             finalize;
  } ctlStrobe_t;
endpackage

// File: rtl/rxen_step_unit.sv
module rxen_step_unit
  import rxen_calib_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [TAP_W-1:0]    tapBound,
  input  logic [TAP_W-1:0]    fineBound,
  input  logic                loadInit,
  input  logic [COARSE_W-1:0] initCoarse,
  input  logic                stepEn,
  input  stepOp_t             stepOp,
  input  logic                finalize,
  input  logic [COARSE_W-1:0] minCoarse,
  output logic [COARSE_W-1:0] coarseOut,
  output logic [TAP_W-1:0]    tapOut,
  output logic [FINE_W-1:0]   fineOut,
  output logic [PHASE_W-1:0]  phaseOut,
  output logic [PRE_W-1:0]    preOut,
  output logic                stepOvf
);
  localparam int SW = 8;

  logic [COARSE_W-1:0] coarseQ;
  logic [TAP_W-1:0]    tapQ;
  logic [FINE_W-1:0]   fineQ;
  logic [PHASE_W-1:0]  phaseQ;
  logic [PRE_W-1:0]    preQ;

  logic signed [SW-1:0] tbS, pbS, dT, dP, dPh, dC;
  logic signed [SW-1:0] nP, nT, nPh, nC, carryT, carryPh, carryC;
  logic [COARSE_W-1:0]  preDiff;

  always_comb begin
    tbS = SW'(signed'({1'b0, tapBound}));
    pbS = SW'(signed'({1'b0, fineBound}));
    dT = '0; dP = '0; dPh = '0; dC = '0;
    case (stepOp)
      OP_TAP2:      dT = SW'(2);
      OP_TAP1:      dT = SW'(1);
      OP_QTR_FWD: begin
        dT = tbS >>> 1;
        dP = tapBound[0] ? (pbS >>> 1) : '0;
      end
      OP_QTR_BACK: begin
        dT = -(tbS >>> 1);
        dP = tapBound[0] ? -(pbS >>> 1) : '0;
      end
      OP_FINE:      dP = SW'(1);
      OP_FULL_BACK: dC = -SW'(1);
      OP_HALF_BACK: dPh = -SW'(PHASE_STEP);
      default: ;
    endcase

    nP = SW'(signed'({1'b0, fineQ})) + dP;
    carryT = '0;
    if (nP >= pbS) begin
      nP = nP - pbS; carryT = SW'(1);
    end else if (nP < 0) begin
      nP = nP + pbS; carryT = -SW'(1);
    end

    nT = SW'(signed'({1'b0, tapQ})) + dT + carryT;
    carryPh = '0;
    if (nT >= tbS) begin
      nT = nT - tbS; carryPh = SW'(PHASE_STEP);
    end else if (nT < 0) begin
      nT = nT + tbS; carryPh = -SW'(PHASE_STEP);
    end

    nPh = SW'(signed'({1'b0, phaseQ})) + dPh + carryPh;
    carryC = '0;
    if (nPh >= SW'(PHASE_BOUND)) begin
      nPh = nPh - SW'(PHASE_BOUND); carryC = SW'(1);
    end else if (nPh < 0) begin
      nPh = nPh + SW'(PHASE_BOUND); carryC = -SW'(1);
    end

    nC = SW'(signed'({1'b0, coarseQ})) + dC + carryC;
    stepOvf = (stepOp != OP_NONE) && ((nC < 0) || (nC > SW'(MAX_COARSE)));
    preDiff = coarseQ - minCoarse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coarseQ <= '0; tapQ <= '0; fineQ <= '0; phaseQ <= '0; preQ <= '0;
    end else if (loadInit) begin
      coarseQ <= initCoarse; tapQ <= '0; fineQ <= '0; phaseQ <= '0; preQ <= '0;
    end else if (finalize) begin
      preQ    <= PRE_W'(preDiff);
      coarseQ <= minCoarse;
    end else if (stepEn && !stepOvf) begin
      fineQ   <= FINE_W'(nP);
      tapQ    <= TAP_W'(nT);
      phaseQ  <= PHASE_W'(nPh);
      coarseQ <= COARSE_W'(nC);
    end
  end

  assign coarseOut = coarseQ;
  assign tapOut    = tapQ;
  assign fineOut   = fineQ;
  assign phaseOut  = phaseQ;
  assign preOut    = preQ;
endmodule

// File: rtl/rxen_calib_dp.sv
module rxen_calib_dp
  import rxen_calib_pkg::*;
#(
  parameter int TAP_BOUND_SLOW  = 12,
  parameter int FINE_BOUND_SLOW = 1,
  parameter int TAP_BOUND_FAST  = 9,
  parameter int FINE_BOUND_FAST = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   ctl,
  input  logic                         rateSel,
  input  logic [COARSE_W-1:0]          initCoarse,
  output logic                         stepOvf,
  output logic [NUM_GROUPS*WORD_W-1:0] grpTiming,
  output logic [WORD_W-1:0]            chanWord
);
  logic                rateQ;
  logic [TAP_W-1:0]    tapBound, fineBound;
  logic [COARSE_W-1:0] coarseV [NUM_GROUPS];
  logic [TAP_W-1:0]    tapV    [NUM_GROUPS];
  logic [FINE_W-1:0]   fineV   [NUM_GROUPS];
  logic [PHASE_W-1:0]  phaseV  [NUM_GROUPS];
  logic [PRE_W-1:0]    preV    [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] ovfV;
  logic [COARSE_W-1:0] minCoarse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rateQ <= 1'b0;
    else if (ctl.loadInit) rateQ <= rateSel;
  end

  assign tapBound  = rateQ ? TAP_W'(TAP_BOUND_FAST)  : TAP_W'(TAP_BOUND_SLOW);
  assign fineBound = rateQ ? TAP_W'(FINE_BOUND_FAST) : TAP_W'(FINE_BOUND_SLOW);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_grp
    rxen_step_unit step_i (
      .clk(clk), .rstN(rstN),
      .tapBound(tapBound), .fineBound(fineBound),
      .loadInit(ctl.loadInit), .initCoarse(initCoarse),
      .stepEn(ctl.stepEn && (ctl.grpSel == GRP_W'(g))),
      .stepOp(ctl.stepOp),
      .finalize(ctl.finalize), .minCoarse(minCoarse),
      .coarseOut(coarseV[g]), .tapOut(tapV[g]), .fineOut(fineV[g]),
      .phaseOut(phaseV[g]), .preOut(preV[g]), .stepOvf(ovfV[g])
    );

    always_comb begin
      grpTiming[g*WORD_W +: WORD_W] = '0;
      grpTiming[g*WORD_W + TAP_LSB   +: TAP_W]   = tapV[g];
      grpTiming[g*WORD_W + FINE_LSB  +: FINE_W]  = fineV[g];
      grpTiming[g*WORD_W + PHASE_LSB +: PHASE_W] = phaseV[g];
      grpTiming[g*WORD_W + PRE_LSB   +: PRE_W]   = preV[g];
    end
  end

  always_comb begin
    minCoarse = coarseV[0];
    for (int g = 1; g < NUM_GROUPS; g++)
      if (coarseV[g] < minCoarse) minCoarse = coarseV[g];
  end

  assign stepOvf = ovfV[ctl.grpSel];

  always_comb begin
    chanWord = '0;
    chanWord[CH_COARSE_LSB +: COARSE_W] = coarseV[ctl.grpSel];
  end
endmodule

// File: rtl/rxen_calib_ctrl.sv
module rxen_calib_ctrl
  import rxen_calib_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              altCard,
  output logic              probeReq,
  output logic [LANE_W-1:0] probeLane,
  input  logic              probeAck,
  input  logic              probeLevel,
  input  logic              stepOvf,
  output ctlStrobe_t        ctl,
  output logic              done,
  output logic              error
);
  typedef enum logic [3:0] {
    S_IDLE, S_SEQ, S_PRB_A, S_PRB_B, S_EVAL, S_STEP, S_FINAL, S_DONE, S_ERR
  } state_t;

  typedef enum logic [3:0] {
    P_LOW, P_E1_ADD, P_E1_HIGH, P_E1_BACK, P_E1_FINE, P_QTR, P_PRE,
    P_E2_ADD, P_E2_HIGH, P_E2_BACK, P_E2_FINE, P_HALF, P_ALT
  } phase_t;

  state_t           state;
  phase_t           phase;
  logic [GRP_W-1:0] grp;
  logic             altQ, advAfter, lvlA, lvlB;
  logic [LANE_W-1:0] laneA, laneB;

  function automatic stepOp_t phaseOp(phase_t p);
    case (p)
      P_E1_ADD, P_E2_ADD:   return OP_TAP2;
      P_E1_BACK, P_E2_BACK: return OP_QTR_BACK;
      P_E1_FINE, P_E2_FINE: return OP_FINE;
      P_PRE:                return OP_FULL_BACK;
      P_HALF:               return OP_HALF_BACK;
      P_ALT:                return OP_TAP1;
      default:              return OP_QTR_FWD;
    endcase
  endfunction

  function automatic logic isLoop(phase_t p);
    return (p == P_LOW) || (p == P_E1_HIGH) || (p == P_E1_FINE) ||
           (p == P_PRE) || (p == P_E2_HIGH) || (p == P_E2_FINE);
  endfunction

  function automatic logic keepGoing(phase_t p, logic a, logic b);
    case (p)
      P_E1_HIGH, P_E2_HIGH: return !a && !b;
      P_E1_FINE, P_E2_FINE: return !(a && b);
      default:              return a || b;
    endcase
  endfunction

  always_comb begin
    if (altQ) begin
      case (grp)
        2'd0:    laneA = 3'd0;
        2'd1:    laneA = 3'd3;
        2'd2:    laneA = 3'd6;
        default: laneA = 3'd5;
      endcase
      laneB = laneA;
    end else begin
      laneA = {grp, 1'b0};
      laneB = {grp, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; phase <= P_LOW; grp <= '0;
      altQ <= 1'b0; advAfter <= 1'b0; lvlA <= 1'b0; lvlB <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERR:
          if (start) begin
            state <= S_SEQ; phase <= P_LOW; grp <= '0; altQ <= altCard;
          end
        S_SEQ:
          if (phase == P_ALT && !altQ) begin
            if (grp == GRP_W'(NUM_GROUPS - 1)) state <= S_FINAL;
            else begin grp <= grp + GRP_W'(1); phase <= P_LOW; end
          end else if (isLoop(phase)) begin
            state <= S_PRB_A;
          end else begin
            advAfter <= 1'b1; state <= S_STEP;
          end
        S_PRB_A:
          if (probeAck) begin lvlA <= probeLevel; state <= S_PRB_B; end
        S_PRB_B:
          if (probeAck) begin lvlB <= probeLevel; state <= S_EVAL; end
        S_EVAL:
          if (keepGoing(phase, lvlA, lvlB)) begin
            advAfter <= 1'b0; state <= S_STEP;
          end else begin
            phase <= phase_t'(phase + 4'd1); state <= S_SEQ;
          end
        S_STEP:
          if (stepOvf) state <= S_ERR;
          else if (advAfter && phase == P_ALT) begin
            if (grp == GRP_W'(NUM_GROUPS - 1)) state <= S_FINAL;
            else begin grp <= grp + GRP_W'(1); phase <= P_LOW; state <= S_SEQ; end
          end else begin
            if (advAfter) phase <= phase_t'(phase + 4'd1);
            state <= S_SEQ;
          end
        S_FINAL: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadInit = start && (state == S_IDLE || state == S_DONE || state == S_ERR);
    ctl.stepEn   = (state == S_STEP);
    ctl.stepOp   = phaseOp(phase);
    ctl.grpSel   = grp;
    ctl.finalize = (state == S_FINAL);
  end

  assign probeReq  = (state == S_PRB_A) || (state == S_PRB_B);
  assign probeLane = (state == S_PRB_B) ? laneB : laneA;
  assign done      = (state == S_DONE);
  assign error     = (state == S_ERR);
endmodule

// File: rtl/rxen_calib.sv
module rxen_calib
  import rxen_calib_pkg::*;
#(
  parameter int TAP_BOUND_SLOW  = 12,
  parameter int FINE_BOUND_SLOW = 1,
  parameter int TAP_BOUND_FAST  = 9,
  parameter int FINE_BOUND_FAST = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         rateSel,
  input  logic         altCard,
  input  logic [3:0]   initCoarse,
  output logic         probeReq,
  output logic [2:0]   probeLane,
  input  logic         probeAck,
  input  logic         probeLevel,
  output logic [127:0] grpTiming,
  output logic [31:0]  chanWord,
  output logic         done,
  output logic         error
);
  ctlStrobe_t ctl;
  logic       stepOvf;

  rxen_calib_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .altCard(altCard),
    .probeReq(probeReq), .probeLane(probeLane),
    .probeAck(probeAck), .probeLevel(probeLevel),
    .stepOvf(stepOvf), .ctl(ctl), .done(done), .error(error)
  );

  rxen_calib_dp #(
    .TAP_BOUND_SLOW(TAP_BOUND_SLOW), .FINE_BOUND_SLOW(FINE_BOUND_SLOW),
    .TAP_BOUND_FAST(TAP_BOUND_FAST), .FINE_BOUND_FAST(FINE_BOUND_FAST)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rateSel(rateSel),
    .initCoarse(initCoarse), .stepOvf(stepOvf),
    .grpTiming(grpTiming), .chanWord(chanWord)
  );
endmodule

// File: rtl/rxen_calib_chk.sv
module rxen_calib_chk (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         probeReq,
  input logic [2:0]   probeLane,
  input logic         probeAck,
  input logic [127:0] grpTiming,
  input logic [31:0]  chanWord,
  input logic         done,
  input logic         error
);
  logic anyPreZero;
  always_comb begin
    anyPreZero = 1'b0;
    for (int g = 0; g < 4; g++)
      if (grpTiming[g*32+20 +: 2] == 2'd0) anyPreZero = 1'b1;
  end

  // R2
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeReq && !probeAck |=> probeReq && $stable(probeLane));

  // R6
  timing_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    probeReq && $past(probeReq) |-> $stable(grpTiming) && $stable(chanWord));

  for (genvar g = 0; g < 4; g++) begin : gen_rng
    // R5
    field_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      (grpTiming[g*32+28 +: 4] < 4'd12) && !grpTiming[g*32+22]);
  end

  // R8
  shared_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> anyPreZero);

  // R10
  done_error_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R10
  error_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    error && !start |=> error && !probeReq);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(grpTiming) && $stable(chanWord));
endmodule

bind rxen_calib rxen_calib_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .probeReq(probeReq),
  .probeLane(probeLane), .probeAck(probeAck), .grpTiming(grpTiming),
  .chanWord(chanWord), .done(done), .error(error)
);

// File: tb/rxen_calib_tb_top.sv
`timescale 1ns/1ps
module rxen_calib_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0, rateSel = 1'b0, altCard = 1'b0;
  logic [3:0]   initCoarse = 4'd0;
  logic         probeReq;
  logic [2:0]   probeLane;
  logic         probeAck = 1'b0, probeLevel = 1'b0;
  logic [127:0] grpTiming;
  logic [31:0]  chanWord;
  logic         done, error;

  int checks = 0, failures = 0;
  int laneEdge [8];
  int laneHits [8];
  int totalProbes = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rxen_calib dut_i (
    .clk(clk), .rstN(rstN), .start(start), .rateSel(rateSel), .altCard(altCard),
    .initCoarse(initCoarse), .probeReq(probeReq), .probeLane(probeLane),
    .probeAck(probeAck), .probeLevel(probeLevel), .grpTiming(grpTiming),
    .chanWord(chanWord), .done(done), .error(error)
  );

  function automatic int tapB(bit r); return r ? 9 : 12; endfunction
  function automatic int fineB(bit r); return r ? 8 : 1; endfunction

  function automatic int altLane(int g);
    case (g) 0: return 0; 1: return 3; 2: return 6; default: return 5; endcase
  endfunction

  // Strobe model: high before the edge, low for one clock of preamble,
  // then eight half-clock toggles starting high, then high again.
  function automatic bit strobe(int e, int d, int h);
    int k;
    if (d < e) return 1'b1;
    if (d < e + 2*h) return 1'b0;
    k = (d - e - 2*h) / h;
    if (k < 8) return (k % 2) == 0;
    return 1'b1;
  endfunction

  function automatic int wordPos(int g, bit r);
    int t, p, ph, c;
    t  = grpTiming[g*32+28 +: 4];
    p  = grpTiming[g*32+24 +: 3];
    ph = grpTiming[g*32+22 +: 2];
    c  = chanWord[7 +: 4];
    return ((c*2 + ph/2)*tapB(r) + t)*fineB(r) + p;
  endfunction

  // probe responder, active on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (probeAck) probeAck = 1'b0;
      else if (probeReq) begin
        int g;
        if (altCard) begin
          g = 0;
          for (int k = 0; k < 4; k++) if (altLane(k) == int'(probeLane)) g = k;
        end else g = int'(probeLane) / 2;
        probeLevel = strobe(laneEdge[probeLane], wordPos(g, rateSel),
                            tapB(rateSel)*fineB(rateSel));
        probeAck = 1'b1;
        laneHits[probeLane]++;
        totalProbes++;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference search over a linear fine-unit position
  function automatic int edgeSearch(int d, int ea, int eb, int h, int q, int pb);
    d += 2*pb;
    while (!strobe(ea, d, h) && !strobe(eb, d, h)) d += q;
    d -= q;
    while (!(strobe(ea, d, h) && strobe(eb, d, h))) d += 1;
    return d;
  endfunction

  function automatic int refGroup(int ea, int eb, int init, bit r, bit alt);
    int h, q, pb, d;
    pb = fineB(r); h = tapB(r)*pb;
    q = (tapB(r)/2)*pb + (tapB(r)%2)*(pb/2);
    d = init*2*h;
    while (strobe(ea, d, h) || strobe(eb, d, h)) d += q;
    d = edgeSearch(d, ea, eb, h, q, pb);
    d += q;
    while (strobe(ea, d, h) || strobe(eb, d, h)) d -= 2*h;
    d = edgeSearch(d, ea, eb, h, q, pb);
    d -= h;
    if (alt) d += pb;
    return d;
  endfunction

  task automatic waitEnd(output bit ok);
    ok = 0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (done || error) begin ok = 1; break; end
    end
    if (!ok) check(0, "watchdog", 0, 1);
  endtask

  task automatic launch(bit r, bit alt, int init);
    @(negedge clk);
    rateSel = r; altCard = alt; initCoarse = 4'(init);
    for (int i = 0; i < 8; i++) laneHits[i] = 0;
    totalProbes = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runAndCompare(bit r, bit alt, int init, string tag);
    int d [4];
    int c [4];
    int minC, h, pb, rem, t, p, ph;
    bit ok;
    logic [31:0] expW;
    launch(r, alt, init);
    waitEnd(ok);
    check(done === 1'b1 && error === 1'b0, {tag, " R11 done"}, {done, error}, 2'b10);
    pb = fineB(r); h = tapB(r)*pb;
    minC = 99;
    for (int g = 0; g < 4; g++) begin
      int ea, eb;
      ea = alt ? laneEdge[altLane(g)] : laneEdge[2*g];
      eb = alt ? laneEdge[altLane(g)] : laneEdge[2*g+1];
      d[g] = refGroup(ea, eb, init, r, alt);
      c[g] = d[g] / (2*h);
      if (c[g] < minC) minC = c[g];
    end
    for (int g = 0; g < 4; g++) begin
      rem = d[g] % (2*h);
      ph = (rem / h) * 2;
      t = (rem % h) / pb;
      p = rem % pb;
      expW = '0;
      expW[31:28] = 4'(t); expW[26:24] = 3'(p);
      expW[23:22] = 2'(ph); expW[21:20] = 2'(c[g] - minC);
      check(grpTiming[g*32 +: 32] == expW,
            {tag, " R4 R5 R8 R9 group word"}, grpTiming[g*32 +: 32], expW);
    end
    check(chanWord == (32'(minC) << 7), {tag, " R8 R9 shared coarse"}, chanWord, 32'(minC) << 7);
    check(totalProbes % 2 == 0 && totalProbes > 0, {tag, " R2 probe pairs"}, totalProbes, 0);
    if (alt) begin
      check(laneHits[1] + laneHits[2] + laneHits[4] + laneHits[7] == 0 &&
            laneHits[0] > 0 && laneHits[3] > 0 && laneHits[5] > 0 && laneHits[6] > 0,
            {tag, " R3 R7 alternate lanes"}, laneHits[1] + laneHits[2], 0);
    end else begin
      int miss = 0;
      for (int i = 0; i < 8; i++) if (laneHits[i] == 0) miss++;
      check(miss == 0, {tag, " R3 normal lanes"}, miss, 0);
    end
    repeat (20) @(negedge clk);
    check(done === 1'b1 && chanWord == (32'(minC) << 7), {tag, " R11 held"}, chanWord, 32'(minC) << 7);
  endtask

  task automatic tskReset();
    check(done === 1'b0 && error === 1'b0 && probeReq === 1'b0, "R1 reset flags",
          {done, error, probeReq}, 0);
    check(grpTiming == '0 && chanWord == '0, "R1 reset words", chanWord, 0);
  endtask

  task automatic tskSlowNormal();
    laneEdge = '{100, 103, 130, 133, 160, 163, 175, 178};
    runAndCompare(1'b0, 1'b0, 2, "slow");
  endtask

  task automatic tskFastNormal();
    laneEdge = '{300, 305, 420, 425, 500, 505, 560, 565};
    runAndCompare(1'b1, 1'b0, 1, "fast");
  endtask

  task automatic tskFastAlt();
    laneEdge = '{300, 999, 999, 420, 999, 560, 500, 999};
    runAndCompare(1'b1, 1'b1, 1, "alt");
  endtask

  task automatic tskSlowAlt();
    laneEdge = '{100, 999, 999, 140, 999, 178, 165, 999};
    runAndCompare(1'b0, 1'b1, 2, "altslow");
  endtask

  task automatic tskRestart();
    @(negedge clk);
    rateSel = 1'b0; altCard = 1'b0; initCoarse = 4'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(grpTiming == '0 && chanWord == (32'd3 << 7) && !done && !error,
          "R1 reload on start", chanWord, 32'd3 << 7);
  endtask

  task automatic tskOverflow();
    bit ok;
    logic [31:0] expW;
    laneEdge = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    launch(1'b0, 1'b0, 14);
    waitEnd(ok);
    check(error === 1'b1 && done === 1'b0, "R10 error raised", {done, error}, 2'b01);
    expW = '0; expW[31:28] = 4'd6; expW[23:22] = 2'd2;
    check(chanWord == (32'd15 << 7) && grpTiming[31:0] == expW,
          "R10 step not applied", grpTiming[31:0], expW);
    repeat (15) @(negedge clk);
    check(error === 1'b1 && probeReq === 1'b0 && done === 1'b0,
          "R10 error held", {error, probeReq}, 2'b10);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tskReset();
    rstN = 1'b1;
    @(negedge clk);
    tskReset();
    tskSlowNormal();
    tskRestart();
    begin bit ok; waitEnd(ok); end
    tskFastNormal();
    tskFastAlt();
    tskSlowAlt();
    tskOverflow();
    tskSlowNormal();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule